// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) resolves read-after-write conflicts and taken branches. It looks at the source register indices of the instructions in execute and decode, and at the destination index and write flag of the instructions in execute, memory and writeback. From these it produces one operand-source select for each of the two execute operands, a hold signal that freezes the program counter and the fetch/decode register, a bubble request that turns the decode/execute register into a no-op, and a flush request for the fetch/decode register.

The whole block is combinational and its outputs are valid in the same cycle as its inputs. When bypassing is built in, results of arithmetic instructions reach execute directly and only a load whose value is needed by the very next instruction costs a cycle. When bypassing is left out, a consumer in decode waits until its producer has reached writeback. The register file is assumed to write in the first half of the cycle and read in the second half.

Top module: `hzd_ctrl`

## Requirements
- R1: Operand selects use the code 2'b00 for the register-file value, 2'b01 for the writeback-stage result and 2'b10 for the memory-stage result; 2'b11 never appears. An execute source equal to the destination of a writing memory-stage instruction selects 2'b10.
- R2: An execute source that matches a writing writeback-stage instruction, and no writing memory-stage instruction, selects 2'b01.
- R3: When both the memory-stage and the writeback-stage instruction write the same register that an execute source reads, the select is 2'b10.
- R4: A destination index of 0, or a producer whose write flag is clear, never causes a bypass select other than 2'b00 and never causes a hold.
- R5: With bypassing built in, a load in execute whose destination equals either decode source raises hold and bubble in that cycle; once the load has moved on to memory the hold clears, so a load followed by its consumer costs exactly one cycle.
- R6: With bypassing built in, a non-load writing instruction in execute or memory whose destination matches a decode source causes no hold.
- R7: With bypassing left out, both selects stay 2'b00, and a decode source that matches the destination of a writing instruction in execute or in memory raises hold and bubble; a match with writeback alone does not.
- R8: A taken-branch request raises flush and bubble and forces hold low in the same cycle.
- R9: Over the dependent sequence load x5; add x6,x5,x1; add x7,x6,x5; sub x8,x7,x6; addi x9,x3 the pipeline holds for 1 cycle with bypassing and for 6 cycles without.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_i | input | 5 | First source index of the instruction in execute |
| ex_rs2_i | input | 5 | Second source index of the instruction in execute |
| id_rs1_i | input | 5 | First source index of the instruction in decode |
| id_rs2_i | input | 5 | Second source index of the instruction in decode |
| ex_rd_i | input | 5 | Destination index of the instruction in execute |
| ex_wr_i | input | 1 | Instruction in execute writes a register |
| ex_load_i | input | 1 | Instruction in execute reads data memory |
| mem_rd_i | input | 5 | Destination index of the instruction in memory |
| mem_wr_i | input | 1 | Instruction in memory writes a register |
| wb_rd_i | input | 5 | Destination index of the instruction in writeback |
| wb_wr_i | input | 1 | Instruction in writeback writes a register |
| branch_taken_i | input | 1 | Branch resolved taken in execute |
| fwd_a_o | output | 2 | Source select for execute operand A |
| fwd_b_o | output | 2 | Source select for execute operand B |
| stall_o | output | 1 | Hold the program counter and fetch/decode register |
| bubble_idex_o | output | 1 | Load a no-op into the decode/execute register |
| flush_ifid_o | output | 1 | Clear the fetch/decode register |

## Verification
The bench builds two copies side by side on shared inputs: one with bypassing on (FWD_EN=1) and one with it off (FWD_EN=0). Every vector is therefore judged against both hold rules at once, so the difference between a one-cycle load penalty and waiting out the producer is visible on identical stimulus. A small instruction-level pipeline model in the bench, advanced by each copy's own hold signal, turns that difference into whole-sequence cycle counts.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    parameter int unsigned REG_IDX_W = 5;
    localparam int unsigned NUM_SRC  = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     wr;
    } prod_t;

    // A producer only matters if it writes a register other than x0.
    function automatic logic prod_live(prod_t p);
        return p.wr && (p.rd != '0);
    endfunction

    function automatic logic prod_hits(prod_t p, reg_idx_t src);
        return prod_live(p) && (p.rd == src);
    endfunction

endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
    import hzd_pkg::*;
#(
    parameter bit FWD_EN = 1'b1
) (
    input  reg_idx_t  src_i,
    input  prod_t     mem_p_i,
    input  prod_t     wb_p_i,
    output opnd_src_e sel_o
);

    generate
        if (FWD_EN) begin : g_bypass
            always_comb begin
                if (prod_hits(mem_p_i, src_i)) begin
                    sel_o = SRC_MEM;
                end else if (prod_hits(wb_p_i, src_i)) begin
                    sel_o = SRC_WB;
                end else begin
                    sel_o = SRC_REGFILE;
                end
            end
        end else begin : g_no_bypass
            assign sel_o = SRC_REGFILE;
        end
    endgenerate

endmodule

// File: rtl/hzd_stall_gen.sv
module hzd_stall_gen
    import hzd_pkg::*;
#(
    parameter int unsigned NUM_WATCH = 1
) (
    input  reg_idx_t id_src_i [NUM_SRC],
    input  prod_t    watch_i  [NUM_WATCH],
    input  logic     branch_i,
    output logic     stall_o
);

    logic conflict;

    always_comb begin
        conflict = 1'b0;
        for (int w = 0; w < NUM_WATCH; w++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (prod_hits(watch_i[w], id_src_i[s])) begin
                    conflict = 1'b1;
                end
            end
        end
    end

    // The decode instruction is discarded on a taken branch, so no hold.
    assign stall_o = conflict && !branch_i;

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
#(
    parameter bit FWD_EN = 1'b1
) (
    input  logic [hzd_pkg::REG_IDX_W-1:0] ex_rs1_i,
    input  logic [hzd_pkg::REG_IDX_W-1:0] ex_rs2_i,
    input  logic [hzd_pkg::REG_IDX_W-1:0] id_rs1_i,
    input  logic [hzd_pkg::REG_IDX_W-1:0] id_rs2_i,
    input  logic [hzd_pkg::REG_IDX_W-1:0] ex_rd_i,
    input  logic                          ex_wr_i,
    input  logic                          ex_load_i,
    input  logic [hzd_pkg::REG_IDX_W-1:0] mem_rd_i,
    input  logic                          mem_wr_i,
    input  logic [hzd_pkg::REG_IDX_W-1:0] wb_rd_i,
    input  logic                          wb_wr_i,
    input  logic                          branch_taken_i,
    output logic [1:0]                    fwd_a_o,
    output logic [1:0]                    fwd_b_o,
    output logic                          stall_o,
    output logic                          bubble_idex_o,
    output logic                          flush_ifid_o
);

    localparam int unsigned NUM_WATCH = FWD_EN ? 1 : 2;

    prod_t     ex_p, mem_p, wb_p;
    reg_idx_t  ex_src [NUM_SRC];
    reg_idx_t  id_src [NUM_SRC];
    opnd_src_e sel    [NUM_SRC];
    prod_t     watch  [NUM_WATCH];
    logic      hold;

    assign ex_p  = '{rd: ex_rd_i,  wr: ex_wr_i};
    assign mem_p = '{rd: mem_rd_i, wr: mem_wr_i};
    assign wb_p  = '{rd: wb_rd_i,  wr: wb_wr_i};

    assign ex_src[0] = ex_rs1_i;
    assign ex_src[1] = ex_rs2_i;
    assign id_src[0] = id_rs1_i;
    assign id_src[1] = id_rs2_i;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
            hzd_fwd_pick #(.FWD_EN(FWD_EN)) u_pick (
                .src_i   (ex_src[s]),
                .mem_p_i (mem_p),
                .wb_p_i  (wb_p),
                .sel_o   (sel[s])
            );
        end

        if (FWD_EN) begin : g_watch_load
            // Only a load in EX cannot be bypassed in time.
            assign watch[0] = '{rd: ex_p.rd, wr: ex_p.wr && ex_load_i};
        end else begin : g_watch_all
            // Without bypassing, wait for EX and MEM producers to reach WB.
            assign watch[0] = ex_p;
            assign watch[1] = mem_p;
        end
    endgenerate

    hzd_stall_gen #(.NUM_WATCH(NUM_WATCH)) u_stall (
        .id_src_i (id_src),
        .watch_i  (watch),
        .branch_i (branch_taken_i),
        .stall_o  (hold)
    );

    assign fwd_a_o       = sel[0];
    assign fwd_b_o       = sel[1];
    assign stall_o       = hold;
    assign bubble_idex_o = hold || branch_taken_i;
    assign flush_ifid_o  = branch_taken_i;

endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
    parameter bit FWD_EN = 1'b1,
    parameter int unsigned W = 5
) (
    input logic [W-1:0] ex_rs1_i,
    input logic [W-1:0] ex_rd_i,
    input logic         ex_load_i,
    input logic [W-1:0] mem_rd_i,
    input logic         mem_wr_i,
    input logic [W-1:0] wb_rd_i,
    input logic         branch_taken_i,
    input logic [1:0]   fwd_a_o,
    input logic [1:0]   fwd_b_o,
    input logic         stall_o,
    input logic         bubble_idex_o,
    input logic         flush_ifid_o
);

    always_comb begin
        if (!$isunknown({ex_rs1_i, ex_rd_i, ex_load_i, mem_rd_i, mem_wr_i,
                         wb_rd_i, branch_taken_i, fwd_a_o, fwd_b_o,
                         stall_o, bubble_idex_o, flush_ifid_o})) begin
            p_sel_legal_r1: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)
                else $error("illegal operand select");
            p_mem_sel_src_r1: assert (fwd_a_o != 2'b10 || (mem_wr_i && mem_rd_i == ex_rs1_i))
                else $error("memory select without matching producer");
            p_x0_quiet_r4: assert (!(ex_rd_i == '0 && mem_rd_i == '0 && wb_rd_i == '0)
                                   || (fwd_a_o == 2'b00 && fwd_b_o == 2'b00 && !stall_o))
                else $error("x0 destination caused bypass or hold");
            p_hold_bubbles_r5: assert (!stall_o || bubble_idex_o)
                else $error("hold without bubble");
            if (FWD_EN) begin
                p_hold_needs_load_r6: assert (!stall_o || ex_load_i)
                    else $error("hold with bypassing but no load in EX");
            end else begin
                p_no_bypass_r7: assert (fwd_a_o == 2'b00 && fwd_b_o == 2'b00)
                    else $error("bypass select with bypassing disabled");
            end
            p_branch_flush_r8: assert (!branch_taken_i || (flush_ifid_o && bubble_idex_o && !stall_o))
                else $error("taken branch not flushed");
        end
    end

endmodule

bind hzd_ctrl hzd_ctrl_chk #(.FWD_EN(FWD_EN), .W(hzd_pkg::REG_IDX_W)) u_chk (
    .ex_rs1_i       (ex_rs1_i),
    .ex_rd_i        (ex_rd_i),
    .ex_load_i      (ex_load_i),
    .mem_rd_i       (mem_rd_i),
    .mem_wr_i       (mem_wr_i),
    .wb_rd_i        (wb_rd_i),
    .branch_taken_i (branch_taken_i),
    .fwd_a_o        (fwd_a_o),
    .fwd_b_o        (fwd_b_o),
    .stall_o        (stall_o),
    .bubble_idex_o  (bubble_idex_o),
    .flush_ifid_o   (flush_ifid_o)
);

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    typedef struct packed {
        logic [4:0] ex_rs1, ex_rs2, id_rs1, id_rs2, ex_rd;
        logic       ex_wr, ex_ld;
        logic [4:0] mem_rd;
        logic       mem_wr;
        logic [4:0] wb_rd;
        logic       wb_wr, br;
        logic [1:0] ea, eb;
        logic       es, ebub, efl, es_nf;
    } vec_t;

    // ex_rs1 ex_rs2 id_rs1 id_rs2 ex_rd ex_wr ex_ld mem_rd mem_wr wb_rd wb_wr br | ea eb es ebub efl es_nf
    localparam vec_t VECS [NV] = '{
        '{5'd1, 5'd2, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // idle
        '{5'd1, 5'd2, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 5'd1, 1'b1, 5'd0, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 mem
        '{5'd1, 5'd2, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd2, 1'b1, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 wb
        '{5'd3, 5'd3, 5'd9, 5'd9, 5'd0, 1'b0, 1'b0, 5'd3, 1'b1, 5'd3, 1'b1, 1'b0, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 priority
        '{5'd3, 5'd4, 5'd9, 5'd9, 5'd0, 1'b0, 1'b0, 5'd3, 1'b0, 5'd3, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 mem no-write
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 x0
        '{5'd1, 5'd2, 5'd5, 5'd6, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 rs1
        '{5'd1, 5'd2, 5'd6, 5'd5, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 rs2
        '{5'd1, 5'd2, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 load x0
        '{5'd1, 5'd2, 5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 alu EX
        '{5'd1, 5'd2, 5'd8, 5'd7, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 mem hold
        '{5'd1, 5'd2, 5'd7, 5'd8, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 wb free
        '{5'd1, 5'd2, 5'd5, 5'd6, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 branch+load
        '{5'd1, 5'd2, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0}  // R8 branch
    };

    typedef struct packed {
        logic [4:0] rd, rs1, rs2;
        logic       wr, ld;
    } ins_t;

    localparam int NP = 5;
    localparam ins_t NOP = '0;
    localparam ins_t PROG [NP] = '{
        '{5'd5, 5'd2, 5'd0, 1'b1, 1'b1},   // load x5
        '{5'd6, 5'd5, 5'd1, 1'b1, 1'b0},   // add x6,x5,x1
        '{5'd7, 5'd6, 5'd5, 1'b1, 1'b0},   // add x7,x6,x5
        '{5'd8, 5'd7, 5'd6, 1'b1, 1'b0},   // sub x8,x7,x6
        '{5'd9, 5'd3, 5'd0, 1'b1, 1'b0}    // addi x9,x3
    };

    logic clk = 1'b0;
    logic rst;
    logic [4:0] ex_rs1, ex_rs2, id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_wr, ex_ld, mem_wr, wb_wr, br;
    logic [1:0] fa, fb, fa_nf, fb_nf;
    logic st, bub, fl, st_nf, bub_nf, fl_nf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_ctrl #(.FWD_EN(1'b1)) i_hzd_ctrl (
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
        .ex_rd_i(ex_rd), .ex_wr_i(ex_wr), .ex_load_i(ex_ld),
        .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .wb_rd_i(wb_rd), .wb_wr_i(wb_wr),
        .branch_taken_i(br), .fwd_a_o(fa), .fwd_b_o(fb), .stall_o(st),
        .bubble_idex_o(bub), .flush_ifid_o(fl)
    );

    hzd_ctrl #(.FWD_EN(1'b0)) i_hzd_ctrl_nf (
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
        .ex_rd_i(ex_rd), .ex_wr_i(ex_wr), .ex_load_i(ex_ld),
        .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .wb_rd_i(wb_rd), .wb_wr_i(wb_wr),
        .branch_taken_i(br), .fwd_a_o(fa_nf), .fwd_b_o(fb_nf), .stall_o(st_nf),
        .bubble_idex_o(bub_nf), .flush_ifid_o(fl_nf)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_stage(input ins_t id_s, input ins_t ex_s, input ins_t mem_s, input ins_t wb_s);
        id_rs1 = id_s.rs1;  id_rs2 = id_s.rs2;
        ex_rs1 = ex_s.rs1;  ex_rs2 = ex_s.rs2;
        ex_rd  = ex_s.rd;   ex_wr  = ex_s.wr;  ex_ld = ex_s.ld;
        mem_rd = mem_s.rd;  mem_wr = mem_s.wr;
        wb_rd  = wb_s.rd;   wb_wr  = wb_s.wr;
        br     = 1'b0;
    endtask

    // Instruction-level pipeline model advanced by the chosen copy's hold.
    task automatic run_seq(input bit use_nf, output int holds);
        ins_t id_s = NOP, ex_s = NOP, mem_s = NOP, wb_s = NOP;
        int pc = 0;
        logic h;
        holds = 0;
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            drive_stage(id_s, ex_s, mem_s, wb_s);
            #1;
            h = use_nf ? st_nf : st;
            if (h) holds++;
            @(posedge clk);
            wb_s  = mem_s;
            mem_s = ex_s;
            if (h) begin
                ex_s = NOP;
            end else begin
                ex_s = id_s;
                id_s = (pc < NP) ? PROG[pc] : NOP;
                pc++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int holds;
        rst = 1'b1;
        drive_stage(NOP, NOP, NOP, NOP);
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Reset state: idle pipeline gives no selects, no hold, no flush.
        @(negedge clk); #1;
        check("R4 reset fwd_a", fa, 0);
        check("R4 reset fwd_b", fb, 0);
        check("R4 reset stall", st, 0);
        check("R8 reset flush", fl, 0);
        check("R7 reset stall nf", st_nf, 0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ex_rs1 = VECS[v].ex_rs1; ex_rs2 = VECS[v].ex_rs2;
            id_rs1 = VECS[v].id_rs1; id_rs2 = VECS[v].id_rs2;
            ex_rd  = VECS[v].ex_rd;  ex_wr  = VECS[v].ex_wr;  ex_ld = VECS[v].ex_ld;
            mem_rd = VECS[v].mem_rd; mem_wr = VECS[v].mem_wr;
            wb_rd  = VECS[v].wb_rd;  wb_wr  = VECS[v].wb_wr;  br = VECS[v].br;
            #1;
            check($sformatf("R1/R2/R3 fwd_a v%0d", v), fa, VECS[v].ea);
            check($sformatf("R1/R2/R3 fwd_b v%0d", v), fb, VECS[v].eb);
            check($sformatf("R5/R6 stall v%0d", v), st, VECS[v].es);
            check($sformatf("R5/R8 bubble v%0d", v), bub, VECS[v].ebub);
            check($sformatf("R8 flush v%0d", v), fl, VECS[v].efl);
            check($sformatf("R7 stall nf v%0d", v), st_nf, VECS[v].es_nf);
            check($sformatf("R7 bubble nf v%0d", v), bub_nf, VECS[v].es_nf | VECS[v].br);
            check($sformatf("R7 sel nf v%0d", v), {fa_nf, fb_nf}, 0);
            check($sformatf("R8 flush nf v%0d", v), fl_nf, VECS[v].br);
        end

        // Sequence-level hold counts.
        run_seq(1'b0, holds);
        check("R9 R5 holds with bypass", holds, 1);
        run_seq(1'b1, holds);
        check("R9 R7 holds without bypass", holds, 6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule